// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a single register stage for the command and address lines of a memory module. On every rising clock edge it samples a data bus and three control lines (chip select, on-die termination enable, clock enable) and presents them as registered outputs. A static configuration input chooses between a wide single-copy arrangement and a narrow dual-copy arrangement. In the dual-copy arrangement each captured bit drives two identical output copies, A and B, so that one register can load two groups of memory devices.

The data outputs can be frozen to save power. When the chip select and a second chip-select-range input are both high at a clock edge, the data outputs keep their previous values. The registered control outputs keep updating in that case. An active-low reset clears every output at once, without waiting for the clock, and wins over the freeze.

A second configuration input picks which part of the wide input bus feeds the narrow register in dual-copy mode. Both configuration inputs are meant to be static. If one changes while the block runs, the change takes effect at the next clock edge.

Top module: `cmdbuf_top`

## Requirements
- R1: In single-copy mode (`modeDual` = 0) with the data path not frozen, `qA` equals the `dataIn` value sampled at the most recent rising edge of `clk`.
- R2: In dual-copy mode (`modeDual` = 1) with the data path not frozen, the lower 14 bits of `qA` and all 14 bits of `qB` both equal the captured 14-bit slice, and `qA` bits 24 to 14 are low.
- R3: In dual-copy mode, `pairSel` = 0 selects `dataIn[13:0]` as the slice and `pairSel` = 1 selects `dataIn[24:11]`. In single-copy mode `pairSel` has no effect on any output.
- R4: When `csIn` and `csRangeIn` are both 1 at a rising edge, `qA` and `qB` keep their previous values.
- R5: `csOutA`, `odtOutA` and `ckeOutA` take the values of `csIn`, `odtIn` and `ckeIn` at every rising edge, frozen or not. In dual-copy mode `csOutB`, `odtOutB` and `ckeOutB` carry the same values.
- R6: While `rstN` is 0 every output is 0 at once, with no clock edge needed, whatever the chip-select inputs are.
- R7: In single-copy mode `qB`, `csOutB`, `odtOutB` and `ckeOutB` are all 0.
- R8: With `csRangeIn` = 0 the data path never freezes, and a high `csIn` behaves like any other captured input.
- R9: A change of `modeDual` takes effect at the next rising edge, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeDual | input | 1 | 0: wide single copy, 1: narrow dual copy |
| pairSel | input | 1 | Dual-copy slice select: 0 low lanes, 1 high lanes |
| dataIn | input | 25 | Command/address data bus |
| csIn | input | 1 | Chip select |
| csRangeIn | input | 1 | Chip-select range input that enables freezing |
| odtIn | input | 1 | On-die termination enable |
| ckeIn | input | 1 | Clock enable |
| qA | output | 25 | Registered data, copy A |
| qB | output | 14 | Registered data, copy B |
| csOutA | output | 1 | Registered chip select, copy A |
| csOutB | output | 1 | Registered chip select, copy B |
| odtOutA | output | 1 | Registered termination enable, copy A |
| odtOutB | output | 1 | Registered termination enable, copy B |
| ckeOutA | output | 1 | Registered clock enable, copy A |
| ckeOutB | output | 1 | Registered clock enable, copy B |

## Verification
Random data words are applied in both modes and with both slice selects. This separates a correct wide capture from a wrong slice choice or missing zero padding, and it shows whether copy B mirrors copy A. The chip-select pair is driven through all four combinations. Only the both-high case may freeze the data outputs, and the control outputs must move in every case. Directed cases assert reset in the middle of a cycle with the freeze inputs high, release it, and switch the mode in the middle of a run, so that a design that leaks reset to the clock or applies the mode change too early or too late is caught.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

  localparam int unsigned DefWideW   = 25;
  localparam int unsigned DefNarrowW = 14;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadData;    // data register captures at this edge
    logic wideCapture; // capture full bus (single-copy mode)
    logic pickUpper;   // dual mode: take the upper slice of the bus
    logic dualOn;      // registered mode: B copies enabled
  } ctlStrobe_t;

  // Registered control lines.
  typedef struct packed {
    logic cs;
    logic odt;
    logic cke;
  } ctlLines_t;

endpackage

// File: rtl/cmdbuf_control.sv
module cmdbuf_control
  import cmdbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeDual,
  input  logic       pairSel,
  input  logic       csIn,
  input  logic       csRangeIn,
  output ctlStrobe_t strobe
);

  logic modeReg;
  logic freezeNow;

  // Freeze only when both chip-select inputs are high.
  assign freezeNow = csIn & csRangeIn;

  // Mode seen by the output fan-out changes at the clock edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= 1'b0;
    else       modeReg <= modeDual;
  end

  always_comb begin
    strobe.loadData    = ~freezeNow;
    strobe.wideCapture = ~modeDual;
    strobe.pickUpper   = modeDual & pairSel;
    strobe.dualOn      = modeReg;
  end

endmodule

// File: rtl/cmdbuf_datapath.sv
module cmdbuf_datapath
  import cmdbuf_pkg::*;
#(
  parameter int unsigned WIDE_W   = DefWideW,
  parameter int unsigned NARROW_W = DefNarrowW
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [WIDE_W-1:0]   dataIn,
  input  logic                csIn,
  input  logic                odtIn,
  input  logic                ckeIn,
  output logic [WIDE_W-1:0]   qA,
  output logic [NARROW_W-1:0] qB,
  output logic                csOutA,
  output logic                csOutB,
  output logic                odtOutA,
  output logic                odtOutB,
  output logic                ckeOutA,
  output logic                ckeOutB
);

  localparam int unsigned PadW   = WIDE_W - NARROW_W;
  localparam int unsigned UpperLo = WIDE_W - NARROW_W;

  logic [NARROW_W-1:0] narrowSel;
  logic [WIDE_W-1:0]   nextData;
  logic [WIDE_W-1:0]   dataReg;
  ctlLines_t           ctlReg;
  logic [NARROW_W-1:0] copyB;

  // Per-lane slice select for the narrow register.
  for (genvar i = 0; i < NARROW_W; i++) begin : g_lane
    assign narrowSel[i] = strobe.pickUpper ? dataIn[UpperLo + i] : dataIn[i];
  end

  if (PadW > 0) begin : g_pad
    assign nextData = strobe.wideCapture ? dataIn : {{PadW{1'b0}}, narrowSel};
  end else begin : g_nopad
    assign nextData = strobe.wideCapture ? dataIn : narrowSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataReg <= '0;
    else if (strobe.loadData) dataReg <= nextData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlReg <= '0;
    else       ctlReg <= '{cs: csIn, odt: odtIn, cke: ckeIn};
  end

  // B copy fan-out, driven low in single-copy mode.
  for (genvar j = 0; j < NARROW_W; j++) begin : g_copyB
    assign copyB[j] = strobe.dualOn & dataReg[j];
  end

  assign qA      = dataReg;
  assign qB      = copyB;
  assign csOutA  = ctlReg.cs;
  assign odtOutA = ctlReg.odt;
  assign ckeOutA = ctlReg.cke;
  assign csOutB  = strobe.dualOn & ctlReg.cs;
  assign odtOutB = strobe.dualOn & ctlReg.odt;
  assign ckeOutB = strobe.dualOn & ctlReg.cke;

endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top
  import cmdbuf_pkg::*;
#(
  parameter int unsigned WIDE_W   = DefWideW,
  parameter int unsigned NARROW_W = DefNarrowW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeDual,
  input  logic                pairSel,
  input  logic [WIDE_W-1:0]   dataIn,
  input  logic                csIn,
  input  logic                csRangeIn,
  input  logic                odtIn,
  input  logic                ckeIn,
  output logic [WIDE_W-1:0]   qA,
  output logic [NARROW_W-1:0] qB,
  output logic                csOutA,
  output logic                csOutB,
  output logic                odtOutA,
  output logic                odtOutB,
  output logic                ckeOutA,
  output logic                ckeOutB
);

  ctlStrobe_t strobe;

  cmdbuf_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .modeDual  (modeDual),
    .pairSel   (pairSel),
    .csIn      (csIn),
    .csRangeIn (csRangeIn),
    .strobe    (strobe)
  );

  cmdbuf_datapath #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .csIn    (csIn),
    .odtIn   (odtIn),
    .ckeIn   (ckeIn),
    .qA      (qA),
    .qB      (qB),
    .csOutA  (csOutA),
    .csOutB  (csOutB),
    .odtOutA (odtOutA),
    .odtOutB (odtOutB),
    .ckeOutA (ckeOutA),
    .ckeOutB (ckeOutB)
  );

endmodule

// File: rtl/cmdbuf_checker.sv
module cmdbuf_checker #(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input logic                clk,
  input logic                rstN,
  input logic                modeDual,
  input logic [WIDE_W-1:0]   dataIn,
  input logic                csIn,
  input logic                csRangeIn,
  input logic                odtIn,
  input logic                ckeIn,
  input logic [WIDE_W-1:0]   qA,
  input logic [NARROW_W-1:0] qB,
  input logic                csOutA,
  input logic                csOutB,
  input logic                odtOutA,
  input logic                odtOutB,
  input logic                ckeOutA,
  input logic                ckeOutB
);

  // R1: single-copy capture with one edge of latency
  a_r1_wide_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!modeDual && !(csIn && csRangeIn)) |=> (qA == $past(dataIn)));

  // R2: both copies agree in dual-copy mode
  a_r2_copies_match: assert property (@(posedge clk) disable iff (!rstN)
    (modeDual && !(csIn && csRangeIn)) |=> (qB == qA[NARROW_W-1:0]));

  // R4: freeze holds the data outputs
  a_r4_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    (csIn && csRangeIn && $stable(modeDual)) |=> ($stable(qA) && $stable(qB)));

  // R5: control copy A follows every edge
  a_r5_ctl_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (csOutA == $past(csIn) && odtOutA == $past(odtIn) && ckeOutA == $past(ckeIn)));

  // R7: B copies low in single-copy mode
  a_r7_b_low: assert property (@(posedge clk) disable iff (!rstN)
    !modeDual |=> (qB == '0 && !csOutB && !odtOutB && !ckeOutB));

  // R6: sampled away from the edge; reset itself is the antecedent
  a_r6_reset_clears: assert property (@(negedge clk)
    !rstN |-> (qA == '0 && qB == '0 && !csOutA && !csOutB &&
               !odtOutA && !odtOutB && !ckeOutA && !ckeOutB));

endmodule

bind cmdbuf_top cmdbuf_checker #(
  .WIDE_W   (WIDE_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeDual  (modeDual),
  .dataIn    (dataIn),
  .csIn      (csIn),
  .csRangeIn (csRangeIn),
  .odtIn     (odtIn),
  .ckeIn     (ckeIn),
  .qA        (qA),
  .qB        (qB),
  .csOutA    (csOutA),
  .csOutB    (csOutB),
  .odtOutA   (odtOutA),
  .odtOutB   (odtOutB),
  .ckeOutA   (ckeOutA),
  .ckeOutB   (ckeOutB)
);

// File: tb/sim_cmdbuf_top.sv
`timescale 1ns/1ps
module sim_cmdbuf_top;

  localparam int WW = 25;
  localparam int NW = 14;
  localparam int ClkPeriod = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeDual = 1'b0, pairSel = 1'b0;
  logic [WW-1:0] dataIn = '0;
  logic          csIn = 1'b0, csRangeIn = 1'b0, odtIn = 1'b0, ckeIn = 1'b0;
  logic [WW-1:0] qA;
  logic [NW-1:0] qB;
  logic csOutA, csOutB, odtOutA, odtOutB, ckeOutA, ckeOutB;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // Bench model state
  logic [WW-1:0] mData = '0;
  logic mCs = 0, mOdt = 0, mCke = 0, mDual = 0;

  always #(ClkPeriod/2) clk = ~clk;

  cmdbuf_top u0 (.*);

  function automatic logic [WW-1:0] nextWord(logic [WW-1:0] prev, logic [WW-1:0] d,
                                             logic dual, logic sel, logic cs, logic csr);
    logic [WW-1:0] w;
    if (cs && csr) return prev;
    if (!dual) return d;
    w = '0;
    w[NW-1:0] = sel ? d[WW-1 -: NW] : d[NW-1:0];
    return w;
  endfunction

  function automatic logic [NW-1:0] expB();
    return mDual ? mData[NW-1:0] : '0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    chk({req, " qA"}, 64'(qA), 64'(mData));
    chk({req, " qB"}, 64'(qB), 64'(expB()));
    chk({req, " ctlA"}, 64'({csOutA, odtOutA, ckeOutA}), 64'({mCs, mOdt, mCke}));
    chk({req, " ctlB"}, 64'({csOutB, odtOutB, ckeOutB}),
        64'(mDual ? {mCs, mOdt, mCke} : 3'b000));
  endtask

  // Called at a negedge: apply inputs, advance model, check at the next negedge.
  task automatic step(string req, logic dual, logic sel, logic [WW-1:0] d,
                      logic cs, logic csr, logic odt, logic cke);
    modeDual = dual; pairSel = sel; dataIn = d;
    csIn = cs; csRangeIn = csr; odtIn = odt; ckeIn = cke;
    mData = nextWord(mData, d, dual, sel, cs, csr);
    mCs = cs; mOdt = odt; mCke = cke; mDual = dual;
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0D));
    repeat (3) @(negedge clk);
    checkAll("R6 reset state");
    rstN = 1'b1;
    @(negedge clk);

    // R1 single copy capture
    step("R1", 0, 0, 25'h1ABCDEF, 0, 0, 1, 0);
    step("R1", 0, 0, 25'h0F0F0F0, 1, 0, 0, 1);
    // R3: pairSel ignored in single mode
    step("R3 single ignores pairSel", 0, 1, 25'h1555555, 0, 1, 1, 1);
    // R2/R3 dual copy, both slices
    step("R2 R3 low slice", 1, 0, 25'h1FFC000 | 25'h0001234, 0, 0, 0, 1);
    step("R2 R3 high slice", 1, 1, 25'h1F00000 | 25'h00007FF, 1, 0, 1, 0);
    // R4 freeze holds data, R5 controls still move
    step("R4 R5 freeze dual", 1, 0, 25'h0AAAAAA, 1, 1, 0, 0);
    step("R4 R5 freeze dual", 1, 1, 25'h1555555, 1, 1, 1, 1);
    // R8: csRange low never freezes
    step("R8 cs high range low", 0, 0, 25'h0123456, 1, 0, 0, 0);
    step("R8 cs high range low", 0, 0, 25'h1765432, 1, 0, 1, 0);
    // R9 mode change lands at next edge: before the edge, B still low
    @(negedge clk);
    modeDual = 1'b1; pairSel = 1'b0; dataIn = 25'h0003FFF; csIn = 0; csRangeIn = 0;
    #1;
    chk("R9 before edge qB", 64'(qB), 64'(expB()));
    mData = nextWord(mData, dataIn, 1, 0, 0, 0);
    mCs = 0; mOdt = odtIn; mCke = ckeIn; mDual = 1;
    @(negedge clk);
    checkAll("R9 after edge");
    // R7 back to single: B copies low
    step("R7 single B low", 0, 0, 25'h1FFFFFF, 1, 0, 1, 1);

    // R6: async reset mid-cycle with freeze inputs high
    step("R6 prep", 1, 0, 25'h0002A5A, 1, 0, 1, 1);
    csIn = 1; csRangeIn = 1;
    #2 rstN = 1'b0;
    #1;
    mData = '0; mCs = 0; mOdt = 0; mCke = 0; mDual = 0;
    checkAll("R6 async clear");
    @(negedge clk);
    rstN = 1'b1;
    step("R6 R4 frozen after release", 1, 0, 25'h1FFFFFF, 1, 1, 0, 0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      step("R1 R2 R4 R5 random", 1'($urandom), 1'($urandom), WW'($urandom),
           1'($urandom), 1'(($urandom % 3) == 0), 1'($urandom), 1'($urandom));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule